// File: doc/BRIEF.md
# Power-On Secure Boot Sequencer

This block is the first piece of logic to act after power-up, before any boot processor runs. It holds the processor in reset and keeps every debug and test port locked. It then reads a halt-on-error fuse bit and walks a bank of external control registers. Each register is first cleared to zero, and a second pass reads every one back to confirm that it holds zero. Next it streams the read-only boot program, word by word, into an external SHA-3/384 hash engine. It captures the digest and compares all 384 bits with a golden digest kept on chip.

A matching digest releases the processor and the debug lock. A mismatch, or a register that does not read back as zero, sets a sticky error bit. What happens next depends on the fuse bit. With the fuse clear, the sequence carries on, so that later firmware can judge the error. A hash mismatch then ends in a finished state with the processor still held. With the fuse set, the first error drives the block into a terminal lockdown. Only a power-on reset leaves that state. The fuse store, the register bank, the boot ROM and the hash engine all sit outside the block, each reached through a plain request/response port.

Top module: `boot_guard_seq`

## Requirements
- R1: Through reset and at every point before release, dbg_lock and proc_rst_hold are 1. During reset, boot_done is 0 and boot_status is 0. No fuse, register or ROM request is made while dbg_lock is 0.
- R2: After the fuse read, reg_clr is pulsed once for each address 0 to NREGS-1 in ascending order. Then reg_rd is pulsed once for each address in the same order. Each reg_rdata, returned one cycle after its reg_rd, must be zero.
- R3: Before the processor is released, hash_start pulses once. The ROM words at addresses 0 to ROM_WORDS-1 are then passed to hash_data in address order, one hash_wr per word, and hash_last is high only with the final word.
- R4: The captured digest is compared with golden_digest over all DIG_W bits. Only equality releases the block: proc_rst_hold=0, dbg_lock=0, boot_done=1 and boot_status bit 3 set.
- R5: A digest mismatch with the halt fuse clear sets boot_status bit 1 and boot_done. The processor stays in reset and lockdown (bit 2) stays clear, so boot_status=4'b0010, or 4'b0011 if a register error was also seen.
- R6: With the halt fuse set, the first error enters lockdown and sets boot_status bit 2. A register verify error gives 4'b0101, and hash_start is never pulsed. A digest mismatch gives 4'b0110.
- R7: Once the block has finished, its outputs no longer change until reset, whatever the fuse, ROM, hash or golden inputs do. In particular, lockdown keeps the processor reset and the debug lock asserted.
- R8: A register verify error with the fuse clear sets boot_status bit 0 and hashing continues. A matching digest then still releases the processor, with boot_status=4'b1001.
- R9: A digest that differs from the golden value in any single bit, including bit 0 and bit DIG_W-1, counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| dbg_lock | output | 1 | 1 keeps debug and test ports locked |
| proc_rst_hold | output | 1 | 1 holds the boot processor in reset |
| fuse_req | output | 1 | Request for the halt fuse bit |
| fuse_vld | input | 1 | Fuse answer valid |
| fuse_halt | input | 1 | Halt-on-error fuse value |
| reg_clr | output | 1 | Clear the register at reg_addr to zero |
| reg_rd | output | 1 | Read the register at reg_addr |
| reg_addr | output | $clog2(NREGS) | Register address |
| reg_rdata | input | REG_W | Read data, one cycle after reg_rd |
| rom_req | output | 1 | ROM read request, held until rom_vld |
| rom_addr | output | $clog2(ROM_WORDS) | ROM word address |
| rom_vld | input | 1 | ROM data valid |
| rom_data | input | WORD_W | ROM word |
| hash_start | output | 1 | Start a new digest |
| hash_wr | output | 1 | hash_data valid |
| hash_data | output | WORD_W | Word to hash |
| hash_last | output | 1 | Final word of the message |
| hash_done | input | 1 | Digest valid pulse |
| hash_digest | input | DIG_W | Computed digest |
| golden_digest | input | DIG_W | Stored reference digest |
| boot_done | output | 1 | Sequence has finished |
| boot_status | output | 4 | bit0 register error, bit1 hash error, bit2 lockdown, bit3 released |

## Verification
The bench builds the block with NREGS=5 and ROM_WORDS=12 and keeps WORD_W=32 and DIG_W=384. These small sizes let each run stay short, so many boots fit in the budget. A stuck bit can then be placed on the first, the last or a random register, and the final-word marker falls on a short stream. The full 384-bit digest width is kept, so that single-bit flips at bit 0, bit 383 and random positions check the whole compare.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [3:0] {
    BG_LOCK, BG_FUSE, BG_SCRUB, BG_SWAIT, BG_HASH,
    BG_HWAIT, BG_RUN, BG_FAILED, BG_LOCKDOWN
  } bg_state_e;

  typedef enum logic [1:0] {SC_IDLE, SC_WR, SC_RD, SC_TAIL} scrub_ph_e;

  localparam int STB_REG_ERR  = 0;
  localparam int STB_HASH_ERR = 1;
  localparam int STB_LOCKDN   = 2;
  localparam int STB_RELEASED = 3;
endpackage

// File: rtl/bg_reg_scrub.sv
module bg_reg_scrub
  import boot_guard_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int REG_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     reg_clr,
  output logic                     reg_rd,
  output logic [$clog2(NREGS)-1:0] reg_addr,
  input  logic [REG_W-1:0]         reg_rdata,
  output logic                     done,
  output logic                     fail
);
  localparam int AW = $clog2(NREGS);
  localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

  scrub_ph_e     ph_q, ph_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          chk_q, chk_d;
  logic          fail_q, fail_d;
  logic          done_q, done_d;

  always_comb begin
    ph_d    = ph_q;
    idx_d   = idx_q;
    chk_d   = 1'b0;
    done_d  = 1'b0;
    fail_d  = fail_q;
    reg_clr = 1'b0;
    reg_rd  = 1'b0;
    // read data of the previous cycle's reg_rd is checked here
    if (chk_q && (reg_rdata != '0)) fail_d = 1'b1;
    unique case (ph_q)
      SC_IDLE: if (start) begin
        ph_d   = SC_WR;
        idx_d  = '0;
        fail_d = 1'b0;
      end
      SC_WR: begin
        reg_clr = 1'b1;
        if (idx_q == LAST) begin
          idx_d = '0;
          ph_d  = SC_RD;
        end else idx_d = idx_q + 1'b1;
      end
      SC_RD: begin
        reg_rd = 1'b1;
        chk_d  = 1'b1;
        if (idx_q == LAST) ph_d = SC_TAIL;
        else idx_d = idx_q + 1'b1;
      end
      SC_TAIL: begin
        done_d = 1'b1;
        ph_d   = SC_IDLE;
      end
      default: ph_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= SC_IDLE;
      idx_q  <= '0;
      chk_q  <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      chk_q  <= chk_d;
      fail_q <= fail_d;
      done_q <= done_d;
    end
  end

  assign reg_addr = idx_q;
  assign done     = done_q;
  assign fail     = fail_q;

  // R2: a clear pass never overlaps a verify pass
  a_r2_clear_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_clr);
endmodule

// File: rtl/bg_rom_feed.sv
module bg_rom_feed #(
  parameter int ROM_WORDS = 64,
  parameter int WORD_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         rom_req,
  output logic [$clog2(ROM_WORDS)-1:0] rom_addr,
  input  logic                         rom_vld,
  input  logic [WORD_W-1:0]            rom_data,
  output logic                         hash_start,
  output logic                         hash_wr,
  output logic [WORD_W-1:0]            hash_data,
  output logic                         hash_last
);
  localparam int AW = $clog2(ROM_WORDS);
  localparam logic [AW-1:0] LAST = AW'(ROM_WORDS - 1);

  logic          busy_q, busy_d;
  logic [AW-1:0] idx_q, idx_d;

  assign hash_start = start & ~busy_q;
  assign rom_req    = busy_q;
  assign rom_addr   = idx_q;
  assign hash_wr    = busy_q & rom_vld;
  assign hash_data  = rom_data;
  assign hash_last  = hash_wr & (idx_q == LAST);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (hash_start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (hash_wr) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // R3: once the final word is sent, no further word follows it
  a_r3_stream_ends: assert property (@(posedge clk) disable iff (!rst_n)
    hash_last |=> !hash_wr);
endmodule

// File: rtl/bg_digest_cmp.sv
module bg_digest_cmp #(
  parameter int DIG_W = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hash_done,
  input  logic [DIG_W-1:0] hash_digest,
  input  logic [DIG_W-1:0] golden,
  output logic             res_valid,
  output logic             res_equal
);
  logic [DIG_W-1:0] dig_q;
  logic             cap_en;
  logic             have_q, have_d;
  logic             rv_q, rv_d;
  logic             eq_q, eq_d;
  logic [DIG_W-1:0] diff;

  assign diff   = dig_q ^ golden;
  assign cap_en = hash_done & ~have_q & ~clear;

  always_comb begin
    have_d = have_q;
    rv_d   = rv_q;
    eq_d   = eq_q;
    if (clear) begin
      have_d = 1'b0;
      rv_d   = 1'b0;
      eq_d   = 1'b0;
    end else if (cap_en) begin
      have_d = 1'b1;
    end else if (have_q && !rv_q) begin
      // verdict taken over every bit at once
      rv_d = 1'b1;
      eq_d = ~|diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      rv_q   <= 1'b0;
      eq_q   <= 1'b0;
    end else begin
      have_q <= have_d;
      rv_q   <= rv_d;
      eq_q   <= eq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dig_q <= '0;
    else if (cap_en) dig_q <= hash_digest;
  end

  assign res_valid = rv_q;
  assign res_equal = eq_q;

  // R4: a verdict, once given, holds until the next clear
  a_r4_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !clear) |=> $stable(res_equal));
endmodule

// File: rtl/boot_guard_seq.sv
module boot_guard_seq
  import boot_guard_pkg::*;
#(
  parameter int ROM_WORDS = 64,
  parameter int WORD_W    = 32,
  parameter int NREGS     = 16,
  parameter int REG_W     = 32,
  parameter int DIG_W     = 384
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic                         dbg_lock,
  output logic                         proc_rst_hold,
  output logic                         fuse_req,
  input  logic                         fuse_vld,
  input  logic                         fuse_halt,
  output logic                         reg_clr,
  output logic                         reg_rd,
  output logic [$clog2(NREGS)-1:0]     reg_addr,
  input  logic [REG_W-1:0]             reg_rdata,
  output logic                         rom_req,
  output logic [$clog2(ROM_WORDS)-1:0] rom_addr,
  input  logic                         rom_vld,
  input  logic [WORD_W-1:0]            rom_data,
  output logic                         hash_start,
  output logic                         hash_wr,
  output logic [WORD_W-1:0]            hash_data,
  output logic                         hash_last,
  input  logic                         hash_done,
  input  logic [DIG_W-1:0]             hash_digest,
  input  logic [DIG_W-1:0]             golden_digest,
  output logic                         boot_done,
  output logic [3:0]                   boot_status
);
  logic [1:0] sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  bg_state_e  st_q, st_d;
  logic       halt_q, halt_en;
  logic [1:0] err_q, err_d;
  logic       scrub_done, scrub_fail, cmp_valid, cmp_eq;
  logic       scrub_start, feed_start, released, lockdn;

  assign scrub_start = (st_q == BG_SCRUB);
  assign feed_start  = (st_q == BG_HASH);

  bg_reg_scrub #(.NREGS(NREGS), .REG_W(REG_W)) u_scrub (
    .clk(clk), .rst_n(rst_int_n), .start(scrub_start),
    .reg_clr(reg_clr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .done(scrub_done), .fail(scrub_fail)
  );

  bg_rom_feed #(.ROM_WORDS(ROM_WORDS), .WORD_W(WORD_W)) u_feed (
    .clk(clk), .rst_n(rst_int_n), .start(feed_start),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_vld(rom_vld),
    .rom_data(rom_data), .hash_start(hash_start), .hash_wr(hash_wr),
    .hash_data(hash_data), .hash_last(hash_last)
  );

  bg_digest_cmp #(.DIG_W(DIG_W)) u_cmp (
    .clk(clk), .rst_n(rst_int_n), .clear(feed_start),
    .hash_done(hash_done), .hash_digest(hash_digest),
    .golden(golden_digest), .res_valid(cmp_valid), .res_equal(cmp_eq)
  );

  always_comb begin
    st_d    = st_q;
    halt_en = 1'b0;
    err_d   = err_q;
    unique case (st_q)
      BG_LOCK:  st_d = BG_FUSE;
      BG_FUSE:  if (fuse_vld) begin
        halt_en = 1'b1;
        st_d    = BG_SCRUB;
      end
      BG_SCRUB: st_d = BG_SWAIT;
      BG_SWAIT: if (scrub_done) begin
        if (scrub_fail) begin
          err_d[STB_REG_ERR] = 1'b1;
          st_d = halt_q ? BG_LOCKDOWN : BG_HASH;
        end else st_d = BG_HASH;
      end
      BG_HASH:  st_d = BG_HWAIT;
      BG_HWAIT: if (cmp_valid) begin
        if (cmp_eq) st_d = BG_RUN;
        else begin
          err_d[STB_HASH_ERR] = 1'b1;
          st_d = halt_q ? BG_LOCKDOWN : BG_FAILED;
        end
      end
      BG_RUN, BG_FAILED, BG_LOCKDOWN: st_d = st_q;
      default: st_d = BG_LOCKDOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= BG_LOCK;
      err_q <= 2'b00;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) halt_q <= 1'b0;
    else if (halt_en) halt_q <= fuse_halt;
  end

  assign released      = (st_q == BG_RUN);
  assign lockdn        = (st_q == BG_LOCKDOWN);
  assign dbg_lock      = ~released;
  assign proc_rst_hold = ~released;
  assign fuse_req      = (st_q == BG_FUSE);
  assign boot_done     = released | lockdn | (st_q == BG_FAILED);
  assign boot_status   = {released, lockdn, err_q};

  // R1: no request of any kind while the debug lock is open
  a_r1_locked_while_active: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_clr || reg_rd || rom_req || fuse_req || hash_wr) |-> (dbg_lock && proc_rst_hold));

  // R4: release follows only from an equal verdict
  a_r4_release_on_match: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == BG_RUN && $past(st_q) != BG_RUN) |-> $past(cmp_valid && cmp_eq));

  // R7: lockdown is terminal
  a_r7_lockdown_terminal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q == BG_LOCKDOWN) |=> (st_q == BG_LOCKDOWN && proc_rst_hold && dbg_lock));

  // R5: logged error bits never clear before reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|err_q) |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R6: a register error under the halt fuse never starts hashing
  a_r6_no_hash_in_lockdown: assert property (@(posedge clk) disable iff (!rst_int_n)
    lockdn |-> !hash_start);
endmodule

// File: tb/tb_boot_guard_seq.sv
module tb_boot_guard_seq;
  localparam int ROM_WORDS = 12;
  localparam int WORD_W    = 32;
  localparam int NREGS     = 5;
  localparam int REG_W     = 32;
  localparam int DIG_W     = 384;
  localparam int RAW       = $clog2(NREGS);
  localparam int OAW       = $clog2(ROM_WORDS);
  localparam logic [DIG_W-1:0] SEED = {12{32'hC3A5_1E0F}};

  logic clk, rst_n;
  logic dbg_lock, proc_rst_hold, fuse_req, fuse_vld, fuse_halt;
  logic reg_clr, reg_rd;
  logic [RAW-1:0] reg_addr;
  logic [REG_W-1:0] reg_rdata;
  logic rom_req, rom_vld;
  logic [OAW-1:0] rom_addr;
  logic [WORD_W-1:0] rom_data, hash_data;
  logic hash_start, hash_wr, hash_last, hash_done;
  logic [DIG_W-1:0] hash_digest, golden_digest;
  logic boot_done;
  logic [3:0] boot_status;

  boot_guard_seq #(.ROM_WORDS(ROM_WORDS), .WORD_W(WORD_W), .NREGS(NREGS),
                   .REG_W(REG_W), .DIG_W(DIG_W)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_lock(dbg_lock), .proc_rst_hold(proc_rst_hold),
    .fuse_req(fuse_req), .fuse_vld(fuse_vld), .fuse_halt(fuse_halt),
    .reg_clr(reg_clr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_vld(rom_vld), .rom_data(rom_data),
    .hash_start(hash_start), .hash_wr(hash_wr), .hash_data(hash_data),
    .hash_last(hash_last), .hash_done(hash_done), .hash_digest(hash_digest),
    .golden_digest(golden_digest), .boot_done(boot_done), .boot_status(boot_status)
  );

  int checks = 0, fails = 0;
  int stuck_idx;
  logic [REG_W-1:0] stuck_mask;
  logic noise;
  logic [REG_W-1:0] regs [NREGS];
  logic [DIG_W-1:0] acc;
  int wr_cnt, rd_cnt, rom_cnt, hs_cnt, open_act;
  logic wr_bad, rd_bad, rom_bad, last_seen;

  function automatic logic [WORD_W-1:0] rom_word(input int i);
    return WORD_W'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [DIG_W-1:0] mix(input logic [DIG_W-1:0] a,
                                           input logic [WORD_W-1:0] w);
    return {a[DIG_W-2:0], a[DIG_W-1]} ^ {12{w}};
  endfunction

  function automatic logic [DIG_W-1:0] exp_digest();
    logic [DIG_W-1:0] a = SEED;
    for (int i = 0; i < ROM_WORDS; i++) a = mix(a, rom_word(i));
    return a;
  endfunction

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // external fuse, register bank, ROM and hash engine models
  initial begin
    fuse_vld = 1'b0; rom_vld = 1'b0; hash_done = 1'b0;
    reg_rdata = '0; rom_data = '0; hash_digest = '0; acc = SEED;
    forever begin
      @(posedge clk);
      if (noise) begin
        fuse_vld    <= 1'($urandom);
        rom_vld     <= 1'($urandom);
        hash_done   <= 1'($urandom);
        hash_digest <= ~hash_digest;
      end else begin
        fuse_vld  <= fuse_req & ~fuse_vld;
        rom_vld   <= rom_req & ~rom_vld & ($urandom % 4 != 0);
        rom_data  <= rom_word(int'(rom_addr));
        hash_done <= 1'b0;
      end
      if ((reg_clr || reg_rd || rom_req || fuse_req) && !dbg_lock) open_act++;
      if (reg_clr) begin
        if (rd_cnt != 0 || int'(reg_addr) != wr_cnt) wr_bad = 1'b1;
        if (int'(reg_addr) < NREGS) regs[reg_addr] <= '0;
        wr_cnt++;
      end
      if (reg_rd) begin
        if (int'(reg_addr) != rd_cnt || wr_cnt != NREGS) rd_bad = 1'b1;
        if (int'(reg_addr) < NREGS)
          reg_rdata <= regs[reg_addr] | ((int'(reg_addr) == stuck_idx) ? stuck_mask : '0);
        rd_cnt++;
      end
      if (hash_start) begin
        hs_cnt++;
        acc <= SEED;
      end else if (hash_wr && !noise) begin
        if (hash_data != rom_word(rom_cnt)) rom_bad = 1'b1;
        if (hash_last != (rom_cnt == ROM_WORDS - 1)) rom_bad = 1'b1;
        if (hash_last) begin
          last_seen = 1'b1;
          hash_done   <= 1'b1;
          hash_digest <= mix(acc, hash_data);
        end
        acc <= mix(acc, hash_data);
        rom_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_boot(input logic halt, input int stuck, input int flip,
                          input string tag);
    logic regerr, hasherr, hs_exp;
    logic [3:0] exp_st;
    int n;
    fuse_halt  = halt;
    stuck_idx  = stuck;
    stuck_mask = REG_W'(1) << ($urandom % REG_W);
    golden_digest = exp_digest() ^ ((flip >= 0) ? (DIG_W'(1) << flip) : '0);
    for (int i = 0; i < NREGS; i++) regs[i] = $urandom | 32'h1;
    wr_cnt = 0; rd_cnt = 0; rom_cnt = 0; hs_cnt = 0; open_act = 0;
    wr_bad = 0; rd_bad = 0; rom_bad = 0; last_seen = 0; noise = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(dbg_lock && proc_rst_hold && !boot_done && boot_status == 4'b0,
        "R1", "reset state {lock,hold,done,status}",
        {dbg_lock, proc_rst_hold, boot_done, boot_status}, 7'b1100000);
    rst_n = 1'b1;
    n = 0;
    while (!boot_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(boot_done, tag, "boot_done", boot_done, 1);
    regerr  = (stuck >= 0);
    hasherr = (flip >= 0);
    if (regerr && halt) begin
      exp_st = 4'b0101;
      hs_exp = 1'b0;
    end else begin
      exp_st = {!hasherr, hasherr && halt, hasherr, regerr};
      hs_exp = 1'b1;
    end
    chk(boot_status == exp_st, tag, "boot_status", boot_status, exp_st);
    chk(proc_rst_hold == !exp_st[3] && dbg_lock == !exp_st[3], "R4",
        "hold/lock after finish", {proc_rst_hold, dbg_lock}, {2{!exp_st[3]}});
    chk(wr_cnt == NREGS && !wr_bad, "R2", "clear pass count/order", wr_cnt, NREGS);
    chk(rd_cnt == NREGS && !rd_bad, "R2", "verify pass count/order", rd_cnt, NREGS);
    chk(open_act == 0, "R1", "requests with debug unlocked", open_act, 0);
    if (hs_exp) begin
      chk(hs_cnt == 1, "R3", "hash_start pulses", hs_cnt, 1);
      chk(rom_cnt == ROM_WORDS && !rom_bad && last_seen, "R3",
          "ROM stream count/order/last", rom_cnt, ROM_WORDS);
    end else begin
      chk(hs_cnt == 0, "R6", "hash_start after register lockdown", hs_cnt, 0);
    end
    // R7 finished state ignores later input activity
    noise = 1'b1;
    golden_digest = ~golden_digest;
    fuse_halt = ~fuse_halt;
    repeat (20) @(negedge clk);
    chk(boot_status == exp_st && boot_done && proc_rst_hold == !exp_st[3]
        && dbg_lock == !exp_st[3], "R7", "state held after input noise",
        {boot_done, proc_rst_hold, boot_status}, {1'b1, !exp_st[3], exp_st});
    noise = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic h;
    int s, f;
    string t;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fuse_halt = 1'b0; noise = 1'b0; stuck_idx = -1;
    stuck_mask = '0; golden_digest = '0;
    run_boot(1'b0, -1, -1, "R4");
    run_boot(1'b1, -1, -1, "R4");
    run_boot(1'b1, NREGS - 1, -1, "R6");
    run_boot(1'b1, 0, -1, "R6");
    run_boot(1'b0, 2, -1, "R8");
    run_boot(1'b0, -1, 0, "R9");
    run_boot(1'b1, -1, DIG_W - 1, "R9");
    run_boot(1'b0, -1, 200, "R5");
    run_boot(1'b0, 1, 77, "R5");
    run_boot(1'b1, -1, 5, "R6");
    for (int k = 0; k < 12; k++) begin
      h = 1'($urandom);
      s = ($urandom % 3 == 0) ? int'($urandom % NREGS) : -1;
      f = ($urandom % 2 == 1) ? int'($urandom % DIG_W) : -1;
      if (s >= 0 && h) t = "R6";
      else if (f >= 0) t = "R5";
      else if (s >= 0) t = "R8";
      else t = "R4";
      run_boot(h, s, f, t);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule